// File: doc/BRIEF.md
# Amplifier Protection Supervisor

This block sits beside a speaker amplifier's output stage. Every clock it reads three digitized sensor codes: die temperature, output current and supply voltage. From them it decides whether the output stage may run and whether the playback path must cut its level. Each detector has its own hysteresis. A warning or a shutdown set by temperature is released only after the die has cooled by a fixed margin. The brownout request is released only after the supply has recovered above its trip point by a margin that depends on the cell mode.

An overcurrent event disables the output stage. The stage then comes back by itself after a fixed number of pulses on a free-running tick input. Thermal shutdown takes precedence over this retry: tick pulses that arrive while the die is too hot are not counted. Each fault condition also sets a sticky status bit the moment it is entered. The host clears these bits by writing ones. The interrupt is the OR of the status bits that the mask lets through.

Top module: `amp_guard`

## Requirements
- R1: After reset, amp_en_o is 1, warn_o is 0, atten_o is 0, status_o is 0 and irq_o is 0.
- R2: The temperature code is in 1 °C per LSB. The warning threshold is 95 + 10·warn_sel_i °C, so code 2 gives 115 °C. warn_o goes high at the clock edge that samples a temperature at or above this threshold.
- R3: Once warn_o is high, it stays high until an edge samples a temperature at or below the warning threshold minus 15 °C.
- R4: The shutdown threshold is 135 + 10·sd_sel_i °C, so code 2 gives 155 °C. A sampled temperature at or above it drives amp_en_o low at that edge. The shutdown is released only by a sample at or below the threshold minus 15 °C.
- R5: The current code is in 10 mA per LSB. A sampled code above 350 (3.5 A) drives amp_en_o low at that edge. A code of exactly 350 has no effect.
- R6: After an overcurrent, amp_en_o returns high at the edge that samples the RETRY_TICKS-th pulse of tick_i (default 20, one pulse per millisecond) after the last sampled overcurrent. A new overcurrent during the retry restarts the count from zero.
- R7: While thermal shutdown is active, tick pulses do not advance the overcurrent retry. No restart happens during a thermal fault.
- R8: The supply code is in mV. bo_sel_i codes above 9 act as 9. The brownout threshold is 2500 + 125·code mV when two_cell_i = 0 and 5000 + 250·code mV when two_cell_i = 1. atten_o rises at the first edge that samples the supply below the threshold. This is one clock, well inside 12 µs for any clock of 1 MHz or faster.
- R9: Once atten_o is high, it falls only at an edge that samples the supply at or above the threshold plus 75 mV (single-cell) or plus 150 mV (two-cell).
- R10: The status_o bits are: bit0 warning, bit1 thermal shutdown, bit2 overcurrent, bit3 brownout. A bit sets at the edge where its condition is entered. It clears at an edge where the same bit of clr_i is 1, even if the condition persists. An entry on the same edge as a clear leaves the bit set. Other bits are unaffected by a clear.
- R11: irq_o is high exactly when (status_o & mask_i) is nonzero, following mask_i without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Free-running retry time base, one-cycle pulses |
| two_cell_i | input | 1 | 1 selects the two-cell brownout scale |
| temp_i | input | 8 | Die temperature, °C |
| cur_i | input | 10 | Output current magnitude, 10 mA/LSB |
| vdd_i | input | 14 | Supply voltage, mV |
| warn_sel_i | input | 2 | Warning threshold code |
| sd_sel_i | input | 2 | Shutdown threshold code |
| bo_sel_i | input | 4 | Brownout threshold code |
| clr_i | input | 4 | Write-one-to-clear strobes for status bits |
| mask_i | input | 4 | Interrupt enable per status bit |
| amp_en_o | output | 1 | Output stage enable |
| warn_o | output | 1 | Thermal warning |
| atten_o | output | 1 | Brownout attenuation request |
| status_o | output | 4 | Sticky fault flags |
| irq_o | output | 1 | Masked interrupt |

## Verification
A hysteresis flag left in the wrong state shows at warn_o, atten_o or amp_en_o one edge after the sample that should have moved it. The bench therefore walks each threshold up and down one code at a time and checks every step. A retry counter that drifts, is not cleared by a repeat overcurrent, or counts during shutdown shows up as amp_en_o returning one or more tick pulses early or late. The bench counts pulses exactly around the RETRY_TICKS boundary. Status faults surface at status_o and irq_o on the entry edge or the clearing edge itself.

// File: rtl/amp_guard.sv
module amp_guard #(
  parameter int TW          = 8,
  parameter int CW          = 10,
  parameter int VW          = 14,
  parameter int WARN_BASE   = 95,
  parameter int SD_BASE     = 135,
  parameter int TEMP_STEP   = 10,
  parameter int TEMP_HYS    = 15,
  parameter int OC_LIMIT    = 350,
  parameter int RETRY_TICKS = 20,
  parameter int BO_MAX_CODE = 9,
  parameter int BO1_BASE    = 2500,
  parameter int BO1_STEP    = 125,
  parameter int BO1_HYS     = 75,
  parameter int BO2_BASE    = 5000,
  parameter int BO2_STEP    = 250,
  parameter int BO2_HYS     = 150
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          two_cell_i,
  input  logic [TW-1:0] temp_i,
  input  logic [CW-1:0] cur_i,
  input  logic [VW-1:0] vdd_i,
  input  logic [1:0]    warn_sel_i,
  input  logic [1:0]    sd_sel_i,
  input  logic [3:0]    bo_sel_i,
  input  logic [3:0]    clr_i,
  input  logic [3:0]    mask_i,
  output logic          amp_en_o,
  output logic          warn_o,
  output logic          atten_o,
  output logic [3:0]    status_o,
  output logic          irq_o
);
  localparam int NW = (VW > TW ? VW : TW) + 2;
  localparam int RW = $clog2(RETRY_TICKS + 1);

  logic [NW-1:0] t_val, v_val, warn_thr, sd_thr, bo_thr, bo_hys;
  logic [3:0]    bo_code;
  logic          warn_q, sd_q, oc_q, bo_q;
  logic          warn_d, sd_d, bo_d, oc_hit;
  logic [RW-1:0] retry_cnt;
  logic [3:0]    entry;

  assign t_val    = NW'(temp_i);
  assign v_val    = NW'(vdd_i);
  assign warn_thr = NW'(WARN_BASE + TEMP_STEP * int'(warn_sel_i));
  assign sd_thr   = NW'(SD_BASE + TEMP_STEP * int'(sd_sel_i));
  assign bo_code  = (int'(bo_sel_i) > BO_MAX_CODE) ? 4'(BO_MAX_CODE) : bo_sel_i;
  assign bo_thr   = two_cell_i ? NW'(BO2_BASE + BO2_STEP * int'(bo_code))
                               : NW'(BO1_BASE + BO1_STEP * int'(bo_code));
  assign bo_hys   = two_cell_i ? NW'(BO2_HYS) : NW'(BO1_HYS);

  assign warn_d = warn_q ? (t_val > warn_thr - NW'(TEMP_HYS)) : (t_val >= warn_thr);
  assign sd_d   = sd_q   ? (t_val > sd_thr - NW'(TEMP_HYS))   : (t_val >= sd_thr);
  assign bo_d   = bo_q   ? (v_val < bo_thr + bo_hys)          : (v_val < bo_thr);
  assign oc_hit = int'(cur_i) > OC_LIMIT;

  assign entry = {bo_d & ~bo_q, oc_hit & ~oc_q, sd_d & ~sd_q, warn_d & ~warn_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_q   <= 1'b0;
      sd_q     <= 1'b0;
      bo_q     <= 1'b0;
      status_o <= '0;
    end else begin
      warn_q   <= warn_d;
      sd_q     <= sd_d;
      bo_q     <= bo_d;
      status_o <= (status_o & ~clr_i) | entry;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oc_q      <= 1'b0;
      retry_cnt <= '0;
    end else if (oc_hit) begin
      oc_q      <= 1'b1;
      retry_cnt <= '0;
    end else if (oc_q && tick_i && !sd_q) begin
      if (retry_cnt == RW'(RETRY_TICKS - 1)) begin
        oc_q      <= 1'b0;
        retry_cnt <= '0;
      end else begin
        retry_cnt <= retry_cnt + 1'b1;
      end
    end
  end

  assign amp_en_o = ~(sd_q | oc_q);
  assign warn_o   = warn_q;
  assign atten_o  = bo_q;
  assign irq_o    = |(status_o & mask_i);
endmodule

// File: rtl/amp_guard_chk.sv
module amp_guard_chk #(
  parameter int TW          = 8,
  parameter int CW          = 10,
  parameter int VW          = 14,
  parameter int WARN_BASE   = 95,
  parameter int SD_BASE     = 135,
  parameter int TEMP_STEP   = 10,
  parameter int OC_LIMIT    = 350,
  parameter int BO_MAX_CODE = 9,
  parameter int BO1_BASE    = 2500,
  parameter int BO1_STEP    = 125,
  parameter int BO2_BASE    = 5000,
  parameter int BO2_STEP    = 250
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          two_cell_i,
  input logic [TW-1:0] temp_i,
  input logic [CW-1:0] cur_i,
  input logic [VW-1:0] vdd_i,
  input logic [1:0]    warn_sel_i,
  input logic [1:0]    sd_sel_i,
  input logic [3:0]    bo_sel_i,
  input logic [3:0]    clr_i,
  input logic          amp_en_o,
  input logic          warn_o,
  input logic          atten_o,
  input logic [3:0]    status_o
);
  int c_code, c_bo_thr, c_warn_thr, c_sd_thr;
  always_comb begin
    c_code     = (int'(bo_sel_i) > BO_MAX_CODE) ? BO_MAX_CODE : int'(bo_sel_i);
    c_bo_thr   = two_cell_i ? BO2_BASE + BO2_STEP * c_code : BO1_BASE + BO1_STEP * c_code;
    c_warn_thr = WARN_BASE + TEMP_STEP * int'(warn_sel_i);
    c_sd_thr   = SD_BASE + TEMP_STEP * int'(sd_sel_i);
  end

  p_warn_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(temp_i) >= c_warn_thr) |=> warn_o);

  p_hot_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(temp_i) >= c_sd_thr) |=> !amp_en_o);

  p_oc_trip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cur_i) > OC_LIMIT) |=> !amp_en_o);

  p_bo_fast_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(vdd_i) < c_bo_thr) |=> atten_o);

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_o) & ~$past(clr_i) & ~status_o) == 4'd0));

  p_warn_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warn_o) |-> status_o[0]);
endmodule

bind amp_guard amp_guard_chk #(
  .TW(TW), .CW(CW), .VW(VW), .WARN_BASE(WARN_BASE), .SD_BASE(SD_BASE),
  .TEMP_STEP(TEMP_STEP), .OC_LIMIT(OC_LIMIT), .BO_MAX_CODE(BO_MAX_CODE),
  .BO1_BASE(BO1_BASE), .BO1_STEP(BO1_STEP), .BO2_BASE(BO2_BASE), .BO2_STEP(BO2_STEP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .two_cell_i(two_cell_i), .temp_i(temp_i),
  .cur_i(cur_i), .vdd_i(vdd_i), .warn_sel_i(warn_sel_i), .sd_sel_i(sd_sel_i),
  .bo_sel_i(bo_sel_i), .clr_i(clr_i), .amp_en_o(amp_en_o), .warn_o(warn_o),
  .atten_o(atten_o), .status_o(status_o)
);

// File: tb/sim_amp_guard.sv
module sim_amp_guard;
  localparam int CLK_PERIOD = 10;
  localparam int RETRY      = 20;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, two_cell = 1'b0;
  logic [7:0]  temp = 8'd25;
  logic [9:0]  cur = '0;
  logic [13:0] vdd = 14'd4000;
  logic [1:0]  warn_sel = 2'd2, sd_sel = 2'd3;
  logic [3:0]  bo_sel = '0, clr = '0, mask = '0;
  logic amp_en, warn, atten, irq;
  logic [3:0] status;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amp_guard #(.RETRY_TICKS(RETRY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .two_cell_i(two_cell),
    .temp_i(temp), .cur_i(cur), .vdd_i(vdd), .warn_sel_i(warn_sel),
    .sd_sel_i(sd_sel), .bo_sel_i(bo_sel), .clr_i(clr), .mask_i(mask),
    .amp_en_o(amp_en), .warn_o(warn), .atten_o(atten), .status_o(status),
    .irq_o(irq));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick_once();
    tick = 1'b1; step(); tick = 1'b0; step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit w, s;
    int thr, bthr, hys, code;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 amp_en", int'(amp_en), 1);
    chk("R1 warn", int'(warn), 0);
    chk("R1 atten", int'(atten), 0);
    chk("R1 status", int'(status), 0);
    chk("R1 irq", int'(irq), 0);

    // R2/R3 warning sweep over every threshold code
    w = 0;
    for (int sel = 0; sel < 4; sel++) begin
      warn_sel = 2'(sel);
      thr = 95 + 10 * sel;
      for (int t = thr - 20; t <= thr + 2; t++) begin
        temp = 8'(t); step();
        w = w ? (t > thr - 15) : (t >= thr);
        chk("R2 warn rising", int'(warn), int'(w));
      end
      for (int t = thr + 2; t >= thr - 20; t--) begin
        temp = 8'(t); step();
        w = w ? (t > thr - 15) : (t >= thr);
        chk("R3 warn falling", int'(warn), int'(w));
      end
    end
    warn_sel = 2'd2;

    // R4 shutdown sweep
    s = 0;
    for (int sel = 0; sel < 4; sel++) begin
      sd_sel = 2'(sel);
      thr = 135 + 10 * sel;
      for (int t = thr - 20; t <= thr + 1; t++) begin
        temp = 8'(t); step();
        s = s ? (t > thr - 15) : (t >= thr);
        chk("R4 shutdown rising", int'(amp_en), int'(!s));
      end
      for (int t = thr + 1; t >= thr - 20; t--) begin
        temp = 8'(t); step();
        s = s ? (t > thr - 15) : (t >= thr);
        chk("R4 shutdown falling", int'(amp_en), int'(!s));
      end
    end
    sd_sel = 2'd3;
    temp = 8'd25; step();

    // R8/R9 brownout thresholds, both scales, codes past the top saturate
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 12; c++) begin
        code = (c > 9) ? 9 : c;
        bthr = (m == 1) ? 5000 + 250 * code : 2500 + 125 * code;
        hys  = (m == 1) ? 150 : 75;
        two_cell = 1'(m); bo_sel = 4'(c);
        vdd = 14'(bthr + hys + 10); step();
        chk("R9 released high", int'(atten), 0);
        vdd = 14'(bthr); step();
        chk("R8 at threshold", int'(atten), 0);
        vdd = 14'(bthr - 1); step();
        chk("R8 below threshold", int'(atten), 1);
        vdd = 14'(bthr + hys - 1); step();
        chk("R9 inside hysteresis", int'(atten), 1);
        vdd = 14'(bthr + hys); step();
        chk("R9 release edge", int'(atten), 0);
      end
    end
    two_cell = 1'b0; bo_sel = 4'd0; vdd = 14'd4000; step();

    // R5 overcurrent limit and R6 retry
    cur = 10'd350; step();
    chk("R5 at limit", int'(amp_en), 1);
    cur = 10'd351; step();
    chk("R5 above limit", int'(amp_en), 0);
    cur = 10'd0;
    for (int i = 1; i < RETRY; i++) begin
      tick_once();
      chk("R6 waiting", int'(amp_en), 0);
    end
    tick_once();
    chk("R6 restart", int'(amp_en), 1);

    cur = 10'd400; step(); cur = 10'd0;
    for (int i = 0; i < 5; i++) tick_once();
    cur = 10'd400; step(); cur = 10'd0;
    chk("R6 retrigger", int'(amp_en), 0);
    for (int i = 1; i < RETRY; i++) begin
      tick_once();
      chk("R6 count restarted", int'(amp_en), 0);
    end
    tick_once();
    chk("R6 restart after retrigger", int'(amp_en), 1);

    // R7 thermal shutdown freezes retry
    cur = 10'd400; step();
    cur = 10'd0; temp = 8'd170; step();
    for (int i = 0; i < RETRY + 2; i++) begin
      tick_once();
      chk("R7 held during shutdown", int'(amp_en), 0);
    end
    temp = 8'd25; step();
    chk("R7 fault still pending", int'(amp_en), 0);
    for (int i = 1; i < RETRY; i++) tick_once();
    chk("R7 not yet", int'(amp_en), 0);
    tick_once();
    chk("R7 restart after cooling", int'(amp_en), 1);

    // R10/R11 status and interrupt
    clr = 4'hF; step(); clr = 4'h0;
    chk("R10 cleared", int'(status), 0);
    mask = 4'hF; #1;
    chk("R11 nothing pending", int'(irq), 0);
    mask = 4'h0;
    temp = 8'd120; step();
    chk("R10 warning entry", int'(status), 1);
    chk("R11 masked off", int'(irq), 0);
    mask = 4'h1; #1;
    chk("R11 mask on", int'(irq), 1);
    clr = 4'b0010; step(); clr = 4'h0;
    chk("R10 other bit kept", int'(status), 1);
    clr = 4'b0001; step(); clr = 4'h0;
    chk("R10 cleared while active", int'(status), 0);
    chk("R10 warn still active", int'(warn), 1);
    step();
    chk("R10 no re-set", int'(status), 0);
    vdd = 14'd2000; clr = 4'b1000; step(); clr = 4'h0;
    chk("R10 entry beats clear", int'(status), 8);
    mask = 4'b0111; #1;
    chk("R11 bit3 masked", int'(irq), 0);
    mask = 4'b1000; #1;
    chk("R11 bit3 enabled", int'(irq), 1);
    temp = 8'd170; step();
    chk("R10 shutdown entry", int'(status[1]), 1);
    cur = 10'd500; step(); cur = 10'd0;
    chk("R10 overcurrent entry", int'(status[2]), 1);

    finish_run();
  end
endmodule